// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the slave side of a four-wire serial bus that behaves like a small byte-addressed EEPROM. A host selects it with an active-low select line and clocks an instruction byte into it, most significant bit first. Depending on that byte, the host then sends an address and data bytes, or collects read data. Read data comes from an internal byte array modelled in registers. The read pointer steps on after each byte and runs on for as long as the clock keeps toggling. Write data is collected into a 16-byte page buffer.

The engine does not keep the status register or time the write cycle itself. When an instruction that changes state completes, it raises `ctl_req` with an operation code and holds it until the neighbouring control block answers on `ctl_gnt`. On the grant of a page write, the buffered bytes are copied into the array. The control block reports a write in progress on `busy_in` and supplies the status byte on `stat_in`.

All bus inputs are synchronised to `clk`, so the bus clock must be several times slower than `clk`. The data output is a value and enable pair (`miso`, `miso_oe`) that drives an external three-state pad.

Top module: `spi_ee_engine`

## Requirements
- R1: The bus clock may idle low or high while select is high. Input bits are taken on the rising edge of the bus clock, and output bits change after the falling edge, most significant bit first.
- R2: The instruction byte is decoded with its bit 3 ignored: 06h write-enable, 04h write-disable, 05h status read, 01h status write, 03h array read, 02h array write.
- R3: After an instruction byte that is not in R2, the block ignores all bus activity until select goes high: `miso_oe` stays low and no request is raised.
- R4: `miso_oe` is high only while status or array data is being returned. It is low while select is high and during instruction and address bytes.
- R5: The array address is bit 3 of the instruction byte (address bit 8), followed by one address byte. Address bits above ADDR_W are ignored.
- R6: A read returns the byte at the address and then successive bytes, and the address wraps from the top of the array to 0.
- R7: Write data bytes go to successive slots of one 16-byte page. The low 4 address bits wrap within the page, so a later byte overwrites an earlier byte in the same slot. The array changes only when the write request is granted.
- R8: A request is raised only when select goes high on a byte boundary after a complete instruction. Write-enable and write-disable need exactly 8 bits, and status write needs exactly 16 bits. Array write needs at least one whole data byte. `ctl_op` is 0 for write-enable, 1 for write-disable, 2 for status write (with the byte on `ctl_wdata`) and 3 for array write. The request and its op and data are held until `ctl_gnt`.
- R9: While `busy_in` is high or a request is pending, the instructions 06h, 04h, 01h and 02h are refused and treated as in R3.
- R10: A status read returns `stat_in` on every byte for as long as the clock runs, also while `busy_in` is high.
- R11: A hold starts when `hold_n` is low while the bus clock is low. It ends when `hold_n` is high while the bus clock is low. During a hold, clock and data are ignored and `miso_oe` is low, and the transfer then resumes from the same bit.
- R12: If `hold_n` falls while the bus clock is high, the hold starts only once the clock is low. Output stays enabled until then.
- R13: After reset, every array byte reads FFh, `ctl_req` is low and `miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Bus select, active low |
| sclk | input | 1 | Bus clock |
| mosi | input | 1 | Bus data into the block |
| hold_n | input | 1 | Pause request, active low |
| miso | output | 1 | Bus data out of the block |
| miso_oe | output | 1 | Drive enable for the data-out pad |
| busy_in | input | 1 | Write cycle in progress, from the control block |
| stat_in | input | 8 | Status byte returned by status read |
| ctl_req | output | 1 | Request to the control block |
| ctl_op | output | 2 | Requested operation (R8 encoding) |
| ctl_wdata | output | 8 | Status byte for a status-write request |
| ctl_gnt | input | 1 | Grant from the control block |

## Verification
The bench goes after the address edges.
- Writes at 1FFh and reads starting at 1FFh check that address bit 8 comes from the instruction byte and that the read wraps to 0. A design that drops that bit would alias the upper half onto the lower half.
- An 18-byte page write checks in-page wrapping. A design that carried into the next page would corrupt the byte at 30h.

It also checks the timing of transactions.
- Select is raised after half an instruction, and write instructions are sent while busy. A design that requested anyway would show up in the grant count.
- Unknown opcodes are sent. A design that did not ignore the bus afterwards would enable the data output.
- Holds are started with the clock low and with the clock high. An engine that honoured the hold at once, or counted clock edges during it, would return a shifted byte.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_SRDATA,
    ST_STAT,
    ST_DONE,
    ST_IGNORE
  } eng_state_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WREN,
    OP_WRDI,
    OP_RDSR,
    OP_WRSR,
    OP_READ,
    OP_WRITE
  } op_kind_t;

  localparam logic [1:0] CTL_WREN  = 2'd0;
  localparam logic [1:0] CTL_WRDI  = 2'd1;
  localparam logic [1:0] CTL_WRSR  = 2'd2;
  localparam logic [1:0] CTL_WRITE = 2'd3;

  // bit 3 of the instruction byte carries address bit 8 and is not decoded
  function automatic op_kind_t decode_op(input logic [7:0] b);
    op_kind_t k;
    case ({b[7:4], b[2:0]})
      7'b0000_110: k = OP_WREN;
      7'b0000_100: k = OP_WRDI;
      7'b0000_101: k = OP_RDSR;
      7'b0000_001: k = OP_WRSR;
      7'b0000_011: k = OP_READ;
      7'b0000_010: k = OP_WRITE;
      default:     k = OP_NONE;
    endcase
    return k;
  endfunction

  // instructions that end in a request to the control block
  function automatic logic needs_grant(input op_kind_t k);
    return (k == OP_WREN) || (k == OP_WRDI) || (k == OP_WRSR) || (k == OP_WRITE);
  endfunction

  // full 9-bit byte address from the instruction's bit 3 and the address byte
  function automatic logic [8:0] addr_of(input logic op_b3, input logic [7:0] ab);
    return {op_b3, ab};
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_ee_hold.sv
module spi_ee_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sclk_s,
  input  logic hold_n_s,
  output logic hold_act
);
  // both transitions are only taken while the bus clock is low, so an
  // edge of hold_n during clock-high waits for the next low phase
  logic enter_ok, leave_ok;
  assign enter_ok = !hold_act && !hold_n_s && !sclk_s;
  assign leave_ok = hold_act && hold_n_s && !sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_act <= 1'b0;
    else if (cs_s)     hold_act <= 1'b0;
    else if (enter_ok) hold_act <= 1'b1;
    else if (leave_ok) hold_act <= 1'b0;
  end
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int SLOTS = 1 << PAGE_W,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              buf_clr,
  input  logic              buf_wr,
  input  logic [PAGE_W-1:0] buf_slot,
  input  logic [7:0]        buf_data,
  input  logic              commit,
  input  logic [PG_W-1:0]   commit_page
);
  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [SLOTS];
  logic [SLOTS-1:0] pvld;

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvld <= '0;
      for (int i = 0; i < SLOTS; i++) pbuf[i] <= 8'h00;
    end else if (buf_clr) begin
      pvld <= '0;
    end else if (buf_wr) begin
      pbuf[buf_slot] <= buf_data;
      pvld[buf_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < SLOTS; i++)
        if (pvld[i]) mem[{commit_page, PAGE_W'(i)}] <= pbuf[i];
    end
  end
endmodule

// File: rtl/spi_ee_engine.sv
module spi_ee_engine
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       hold_n,
  output logic       miso,
  output logic       miso_oe,
  input  logic       busy_in,
  input  logic [7:0] stat_in,
  output logic       ctl_req,
  output logic [1:0] ctl_op,
  output logic [7:0] ctl_wdata,
  input  logic       ctl_gnt
);
  localparam int PG_W = ADDR_W - PAGE_W;

  // ---------------- input synchronisation and events ----------------
  logic cs_s, sclk_s, mosi_s, hold_n_s;
  spi_ee_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, mosi, hold_n}),
    .q({cs_s, sclk_s, mosi_s, hold_n_s})
  );

  logic hold_act;
  spi_ee_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s),
    .hold_n_s(hold_n_s), .hold_act(hold_act)
  );

  logic sclk_d, cs_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  logic rise_ev, fall_ev, cs_rise_ev;
  assign rise_ev    = !cs_s && !hold_act && sclk_s && !sclk_d;
  assign fall_ev    = !cs_s && !hold_act && !sclk_s && sclk_d;
  assign cs_rise_ev = cs_s && !cs_d;

  // ---------------- state ----------------
  eng_state_t        st;
  op_kind_t          op_q;
  logic              op_b3;
  logic [2:0]        bitcnt, obit;
  logic [7:0]        sr_in, tx_sr, wsr_data;
  logic [ADDR_W-1:0] addr_q;
  logic [PG_W-1:0]   commit_pg_q;
  logic              got_data, oe_q, miso_q;

  function automatic logic [ADDR_W-1:0] seq_advance(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] slot_advance(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] s;
    s = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], s};
  endfunction

  // ---------------- combinational decode ----------------
  logic [7:0]        sr_next;
  logic              byte_done, busy_any;
  op_kind_t          dec_op;
  logic [8:0]        addr_full;
  logic [ADDR_W-1:0] addr_cut, rd_addr;
  logic [7:0]        rd_data;

  assign sr_next   = {sr_in[6:0], mosi_s};
  assign byte_done = (bitcnt == 3'd7);
  assign dec_op    = decode_op(sr_next);
  assign addr_full = addr_of(op_b3, sr_next);
  assign addr_cut  = addr_full[ADDR_W-1:0];
  assign rd_addr   = (st == ST_ADDR) ? addr_cut : addr_q;
  assign busy_any  = busy_in || ctl_req;

  logic buf_clr, buf_wr, commit_fire;
  assign buf_clr     = rise_ev && byte_done && (st == ST_ADDR) && (op_q == OP_WRITE);
  assign buf_wr      = rise_ev && byte_done && (st == ST_WDATA);
  assign commit_fire = ctl_req && ctl_gnt && (ctl_op == CTL_WRITE);

  spi_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_clr(buf_clr), .buf_wr(buf_wr),
    .buf_slot(addr_q[PAGE_W-1:0]), .buf_data(sr_next),
    .commit(commit_fire), .commit_page(commit_pg_q)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_OPC;
      op_q        <= OP_NONE;
      op_b3       <= 1'b0;
      bitcnt      <= 3'd0;
      obit        <= 3'd0;
      sr_in       <= 8'h00;
      tx_sr       <= 8'h00;
      wsr_data    <= 8'h00;
      addr_q      <= '0;
      commit_pg_q <= '0;
      got_data    <= 1'b0;
      oe_q        <= 1'b0;
      miso_q      <= 1'b0;
      ctl_req     <= 1'b0;
      ctl_op      <= CTL_WREN;
      ctl_wdata   <= 8'h00;
    end else begin
      if (ctl_req && ctl_gnt) ctl_req <= 1'b0;

      if (cs_s) begin
        st       <= ST_OPC;
        bitcnt   <= 3'd0;
        obit     <= 3'd0;
        oe_q     <= 1'b0;
        got_data <= 1'b0;
        if (cs_rise_ev && !ctl_req) begin
          if (st == ST_DONE) begin
            ctl_req <= 1'b1;
            case (op_q)
              OP_WREN: ctl_op <= CTL_WREN;
              OP_WRDI: ctl_op <= CTL_WRDI;
              default: ctl_op <= CTL_WRSR;
            endcase
            ctl_wdata <= wsr_data;
          end else if (st == ST_WDATA && got_data && bitcnt == 3'd0) begin
            ctl_req     <= 1'b1;
            ctl_op      <= CTL_WRITE;
            commit_pg_q <= addr_q[ADDR_W-1:PAGE_W];
          end
        end
      end else begin
        if (rise_ev) begin
          sr_in  <= sr_next;
          bitcnt <= bitcnt + 3'd1;
          case (st)
            ST_OPC: if (byte_done) begin
              op_q  <= dec_op;
              op_b3 <= sr_next[3];
              if (dec_op == OP_NONE || (busy_any && needs_grant(dec_op))) st <= ST_IGNORE;
              else begin
                case (dec_op)
                  OP_RDSR: begin tx_sr <= stat_in; st <= ST_STAT; end
                  OP_WRSR: st <= ST_SRDATA;
                  OP_READ, OP_WRITE: st <= ST_ADDR;
                  default: st <= ST_DONE;
                endcase
              end
            end
            ST_ADDR: if (byte_done) begin
              if (op_q == OP_READ) begin
                tx_sr  <= rd_data;
                addr_q <= seq_advance(addr_cut);
                st     <= ST_RDATA;
              end else begin
                addr_q <= addr_cut;
                st     <= ST_WDATA;
              end
            end
            ST_WDATA: if (byte_done) begin
              addr_q   <= slot_advance(addr_q);
              got_data <= 1'b1;
            end
            ST_SRDATA: if (byte_done) begin
              wsr_data <= sr_next;
              st       <= ST_DONE;
            end
            ST_DONE: st <= ST_IGNORE;
            default: ;
          endcase
        end

        if (fall_ev && (st == ST_RDATA || st == ST_STAT)) begin
          miso_q <= tx_sr[7];
          oe_q   <= 1'b1;
          obit   <= obit + 3'd1;
          if (obit == 3'd7) begin
            if (st == ST_RDATA) begin
              tx_sr  <= rd_data;
              addr_q <= seq_advance(addr_q);
            end else begin
              tx_sr <= stat_in;
            end
          end else begin
            tx_sr <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q && !hold_act && !cs_s;

endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker
  import spi_ee_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       miso_oe,
  input logic       hold_act,
  input logic       ctl_req,
  input logic       ctl_gnt,
  input logic [1:0] ctl_op,
  input logic [7:0] ctl_wdata,
  input logic       cs_rise_ev,
  input eng_state_t st
);
  a_r11_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !miso_oe);

  a_r4_oe_only_returning: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (st == ST_RDATA || st == ST_STAT));

  a_r3_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !miso_oe);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_req && !ctl_gnt) |=> (ctl_req && $stable(ctl_op) && $stable(ctl_wdata)));

  a_r8_req_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_req) |-> $past(cs_rise_ev));
endmodule

bind spi_ee_engine spi_ee_checker u_chk (
  .clk(clk), .rst_n(rst_n), .miso_oe(miso_oe), .hold_act(hold_act),
  .ctl_req(ctl_req), .ctl_gnt(ctl_gnt), .ctl_op(ctl_op), .ctl_wdata(ctl_wdata),
  .cs_rise_ev(cs_rise_ev), .st(st)
);

// File: tb/spi_ee_engine_bench.sv
module spi_ee_engine_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n_r = 1'b1, sclk_r = 1'b0, mosi_r = 1'b0, hold_n_r = 1'b1;
  logic busy_r = 1'b0;
  logic [7:0] stat_r = 8'h00;
  logic miso, miso_oe, ctl_req, gnt = 1'b0;
  logic [1:0] ctl_op;
  logic [7:0] ctl_wdata;

  int n_chk = 0, n_fail = 0, req_cnt = 0;
  logic [1:0] last_op = 2'd0;
  logic [7:0] last_wd = 8'h00;
  logic cur_mode = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  spi_ee_engine u_spi_ee_engine (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n_r), .sclk(sclk_r), .mosi(mosi_r),
    .hold_n(hold_n_r), .miso(miso), .miso_oe(miso_oe), .busy_in(busy_r),
    .stat_in(stat_r), .ctl_req(ctl_req), .ctl_op(ctl_op), .ctl_wdata(ctl_wdata),
    .ctl_gnt(gnt)
  );

  // control-block model: grants one cycle after a request appears
  always @(posedge clk) begin
    gnt <= ctl_req && !gnt;
    if (ctl_req && gnt) begin
      req_cnt <= req_cnt + 1;
      last_op <= ctl_op;
      last_wd <= ctl_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r, output logic oe);
    sclk_r = 1'b0; mosi_r = b; waitn(HALF);
    r = miso; oe = miso_oe;
    sclk_r = 1'b1; waitn(HALF);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] oev);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i], oev[i]);
  endtask

  task automatic spi_begin(input logic m);
    cur_mode = m; sclk_r = m; waitn(HALF);
    cs_n_r = 1'b0; waitn(HALF);
  endtask

  task automatic spi_end();
    if (!cur_mode) begin sclk_r = 1'b0; waitn(HALF); end
    cs_n_r = 1'b1; waitn(3 * HALF);
    for (int g = 0; g < 200 && ctl_req; g++) waitn(1);
    waitn(2);
  endtask

  function automatic logic [7:0] op_with(input logic [7:0] base, input logic [8:0] a);
    return base | {4'b0, a[8], 3'b0};
  endfunction

  task automatic cmd1(input logic m, input logic [7:0] opc);
    logic [7:0] rx, oev;
    spi_begin(m); spi_byte(opc, rx, oev); spi_end();
  endtask

  task automatic wr1(input logic m, input logic [8:0] a, input logic [7:0] d);
    logic [7:0] rx, oev;
    spi_begin(m);
    spi_byte(op_with(8'h02, a), rx, oev);
    spi_byte(a[7:0], rx, oev);
    spi_byte(d, rx, oev);
    spi_end();
  endtask

  task automatic rd2(input logic m, input logic [8:0] a, output logic [7:0] b0,
                     output logic [7:0] b1, output logic [7:0] oe_addr);
    logic [7:0] rx, oev;
    spi_begin(m);
    spi_byte(op_with(8'h03, a), rx, oev);
    spi_byte(a[7:0], rx, oe_addr);
    spi_byte(8'h00, b0, oev);
    spi_byte(8'h00, b1, oev);
    spi_end();
  endtask

  // reads one byte with a hold placed on its fourth bit
  task automatic rd_hold(input logic [8:0] a, input logic deferred, output logic [7:0] rb);
    logic [7:0] rx, oev;
    logic r, oe;
    spi_begin(1'b0);
    spi_byte(op_with(8'h03, a), rx, oev);
    spi_byte(a[7:0], rx, oev);
    for (int i = 0; i < 3; i++) begin spi_bit(1'b0, r, oe); rb[7-i] = r; end
    if (deferred) begin
      hold_n_r = 1'b0; waitn(HALF);
      chk("R12 output still driven while clock high", miso_oe, 1);
      sclk_r = 1'b0; waitn(HALF);
      chk("R12 hold active after clock low", miso_oe, 0);
    end else begin
      sclk_r = 1'b0; waitn(HALF);
      hold_n_r = 1'b0; waitn(HALF);
      chk("R11 output floats in hold", miso_oe, 0);
    end
    for (int t = 0; t < 3; t++) begin
      mosi_r = t[0]; sclk_r = 1'b1; waitn(HALF);
      sclk_r = 1'b0; waitn(HALF);
    end
    hold_n_r = 1'b1; waitn(HALF);
    rb[4] = miso;
    sclk_r = 1'b1; waitn(HALF);
    for (int i = 4; i < 8; i++) begin spi_bit(1'b0, r, oe); rb[7-i] = r; end
    spi_end();
  endtask

  localparam logic [17:0] VEC [8] = '{
    {1'b0, 9'h000, 8'h3C}, {1'b1, 9'h1FF, 8'hC3}, {1'b0, 9'h100, 8'h5A},
    {1'b1, 9'h0F5, 8'hA7}, {1'b0, 9'h080, 8'h01}, {1'b1, 9'h17F, 8'hFE},
    {1'b0, 9'h0FF, 8'h99}, {1'b1, 9'h101, 8'h42}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1, oea, rx, oev, orall;
    int rc;
    waitn(10);
    rst_n = 1'b1;
    waitn(5);

    // R13 reset state
    chk("R13 oe low after reset", miso_oe, 0);
    chk("R13 no request after reset", ctl_req, 0);
    rd2(1'b0, 9'h010, b0, b1, oea);
    chk("R13 array reads FF", b0, 8'hFF);
    chk("R4 oe low during address byte", oea, 8'h00);

    // vector table: enable, write, read back in both bus modes (R1, R5)
    foreach (VEC[k]) begin
      rc = req_cnt;
      cmd1(VEC[k][17], 8'h06);
      chk("R8 write-enable request", {req_cnt - rc, 30'(last_op)}, {32'd1, 30'(0)} >> 0);
      wr1(VEC[k][17], VEC[k][16:8], VEC[k][7:0]);
      chk("R8 write request op", last_op, 2'd3);
      rd2(VEC[k][17], VEC[k][16:8], b0, b1, oea);
      chk("R5 R1 readback", b0, VEC[k][7:0]);
    end

    // R6 sequential read wraps from top to 0
    rd2(1'b1, 9'h1FF, b0, b1, oea);
    chk("R6 byte at top", b0, 8'hC3);
    chk("R6 wrap to address 0", b1, 8'h3C);
    rd2(1'b0, 9'h0FF, b0, b1, oea);
    chk("R6 increment across 0FF", b1, 8'h5A);

    // R7 page write with in-page wrap
    spi_begin(1'b0);
    spi_byte(8'h02, rx, oev);
    spi_byte(8'h2E, rx, oev);
    for (int i = 0; i < 18; i++) spi_byte(8'h10 + 8'(i), rx, oev);
    spi_end();
    rd2(1'b0, 9'h02E, b0, b1, oea);
    chk("R7 slot E overwritten", b0, 8'h20);
    chk("R7 slot F overwritten", b1, 8'h21);
    rd2(1'b1, 9'h020, b0, b1, oea);
    chk("R7 page start", b0, 8'h12);
    rd2(1'b0, 9'h02D, b0, b1, oea);
    chk("R7 slot D", b0, 8'h1F);
    rd2(1'b0, 9'h030, b0, b1, oea);
    chk("R7 next page untouched", b0, 8'hFF);

    // R10 status read, R8 status write, R2 bit 3 ignored
    stat_r = 8'hA5;
    rc = req_cnt;
    spi_begin(1'b1);
    spi_byte(8'h05, rx, oev);
    spi_byte(8'h00, b0, oev);
    spi_byte(8'h00, b1, oev);
    spi_end();
    chk("R10 status byte", b0, 8'hA5);
    chk("R10 status repeats", b1, 8'hA5);
    spi_begin(1'b0);
    spi_byte(8'h01, rx, oev);
    spi_byte(8'h3C, rx, oev);
    spi_end();
    chk("R8 status write op", last_op, 2'd2);
    chk("R8 status write data", last_wd, 8'h3C);
    cmd1(1'b0, 8'h04);
    chk("R8 write-disable op", last_op, 2'd1);
    cmd1(1'b1, 8'h0E);
    chk("R2 bit 3 ignored on enable", last_op, 2'd0);
    chk("R2 request count", req_cnt - rc, 3);

    // R8 incomplete instruction: select raised after 4 bits
    rc = req_cnt;
    spi_begin(1'b0);
    for (int i = 0; i < 4; i++) spi_bit(1'b0, rx[0], oev[0]);
    spi_end();
    spi_begin(1'b0);
    spi_byte(8'h02, rx, oev); spi_byte(8'h50, rx, oev);
    for (int i = 0; i < 4; i++) spi_bit(1'b1, rx[0], oev[0]);
    spi_end();
    chk("R8 no request for partial frames", req_cnt - rc, 0);

    // R3 unknown opcode
    spi_begin(1'b0);
    spi_byte(8'h07, rx, oev);
    spi_byte(8'h03, rx, orall);
    spi_byte(8'h00, rx, oev);
    spi_end();
    chk("R3 no output after unknown opcode", orall | oev, 8'h00);
    chk("R3 no request after unknown opcode", req_cnt - rc, 0);

    // R9 refused while busy, R10 still answered
    busy_r = 1'b1; stat_r = 8'h81;
    cmd1(1'b0, 8'h06);
    wr1(1'b0, 9'h040, 8'h77);
    chk("R9 no request while busy", req_cnt - rc, 0);
    spi_begin(1'b0);
    spi_byte(8'h05, rx, oev); spi_byte(8'h00, b0, oev);
    spi_end();
    chk("R10 status while busy", b0, 8'h81);
    busy_r = 1'b0;
    rd2(1'b0, 9'h040, b0, b1, oea);
    chk("R9 array unchanged", b0, 8'hFF);

    // R11 / R12 hold
    wr1(1'b0, 9'h0A5, 8'h96);
    rd_hold(9'h0A5, 1'b0, b0);
    chk("R11 byte intact across hold", b0, 8'h96);
    rd_hold(9'h0A5, 1'b1, b0);
    chk("R12 byte intact across deferred hold", b0, 8'h96);
    chk("R4 oe low with select high", miso_oe, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule